// File: doc/BRIEF.md
# Segment Selector Load Unit

This block keeps the six 16-bit segment selector registers of a protected-mode core (numbered 0 = code, 1 = data, 2 = stack, 3 = extra, 4 and 5 = general). Beside each selector it holds a cached copy of the matching descriptor: the decoded base, the decoded limit and the attribute bits. The core starts a load by naming a register and giving a selector. The unit then finds the descriptor in a global table. The table's base address and size are set together by a single table-load command.

The unit reads the 8-byte descriptor as two 32-bit words over a request/acknowledge memory port. It checks the descriptor's type and present bit. When the accessed bit is clear, it writes the upper word back with that bit set. It then commits the selector together with its cached state, or it reports a fault and leaves the register untouched. While a load is in progress the unit reports busy. The current privilege level comes from the selector held in the code register.

Top module: `seg_load_unit`

## Requirements
- R1: After reset, every selector and its cached base, limit and attributes read as zero, all six usable flags are 0, cpl is 0, and busy, done, fault and mem_req are all low.
- R2: A non-null load reads two words. The first is at table base + (selector bits 15:3) * 8 and holds limit 15:0 in bits 15:0 and base 15:0 in bits 31:16. The second is at that address + 4. Each read keeps mem_req and mem_addr steady until mem_ack is seen.
- R3: A selector whose index (bits 15:3) is zero, loaded into register 0 or register 2, raises fault with fault_code 1 (general protection). It makes no memory access and leaves the register unchanged.
- R4: A zero-index selector loaded into registers 1, 3, 4 or 5 commits without any memory access. The register then reads the selector, with base 0, limit 0 and usable 0.
- R5: When (index * 8) + 7 is greater than the table size, a non-null load faults with fault_code 1 and makes no memory access. A value exactly equal to the size is accepted.
- R6: A fetched descriptor with its present bit clear (upper word bit 15) raises fault with fault_code 2. The target register keeps its previous contents.
- R7: When the accessed bit (upper word bit 8) is clear on an otherwise valid descriptor, the unit writes the upper word back to address + 4 with bit 8 set, before it commits. When the bit is already set, no write happens.
- R8: In the upper word, bit 12 must be 1 (not a system entry). Register 0 needs bit 11 set (code). The other registers need bit 11 clear, or bits 11 and 9 both set (readable code). Any other combination gives fault_code 1.
- R9: On commit, rd_base = {upper 31:24, upper 7:0, lower 31:16}. The raw 20-bit limit is {upper 19:16, lower 15:0}. When upper bit 23 is set, rd_limit is the raw limit shifted left by 12 with the low 12 bits filled by 1s; otherwise it is the raw limit. rd_attr = {upper 23:20, upper 15:9, 1}, and usable is 1.
- R10: cpl always equals bits 1:0 of the selector held in register 0.
- R11: busy is high from the cycle after a load is accepted until done or fault pulses for one cycle. Load requests made while busy, and requests naming register 6 or 7, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr | input | 1 | Load table base and size |
| tbl_base | input | 32 | Table base byte address |
| tbl_size | input | 16 | Table size: last valid byte offset |
| ld_req | input | 1 | Start a selector load |
| ld_reg | input | 3 | Target register number, 0 to 5 |
| ld_sel | input | 16 | Selector to load |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse: load committed |
| fault | output | 1 | One-cycle pulse: load rejected |
| fault_code | output | 2 | 1 = general protection, 2 = not present |
| cpl | output | 2 | Current privilege level |
| rd_idx | input | 3 | Register chosen for read-out |
| rd_sel | output | 16 | Selector of the chosen register |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 32 | Cached byte-granular limit |
| rd_attr | output | 12 | Cached flag nibble and access byte |
| rd_usable | output | 1 | Register holds a usable descriptor |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume a memory that pulses mem_ack for one cycle only while mem_req is high, and that delivers mem_rdata in that same cycle. The bench's memory model acknowledges one cycle after each request and then drops the acknowledge, so every request receives exactly one ack. The assertions also assume that the table is not reloaded in the middle of a load. The bench sets the table once, right after reset, and starts every load only after the previous one has finished.

// File: rtl/seg_load_unit.sv
module seg_load_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_wr,
  input  logic [31:0] tbl_base,
  input  logic [15:0] tbl_size,
  input  logic        ld_req,
  input  logic [2:0]  ld_reg,
  input  logic [15:0] ld_sel,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [1:0]  fault_code,
  output logic [1:0]  cpl,
  input  logic [2:0]  rd_idx,
  output logic [15:0] rd_sel,
  output logic [31:0] rd_base,
  output logic [31:0] rd_limit,
  output logic [11:0] rd_attr,
  output logic        rd_usable,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int NSEG = 6;
  localparam logic [1:0] GP = 2'd1, NP = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_WB} st_t;
  st_t st;

  logic [31:0] gbase, daddr, lo_q, hi_q;
  logic [15:0] gsize, nsel;
  logic [2:0]  tgt;
  logic [15:0] sel_q  [NSEG];
  logic [31:0] base_q [NSEG];
  logic [31:0] lim_q  [NSEG];
  logic [11:0] attr_q [NSEG];
  logic [NSEG-1:0] use_q;

  wire [15:0] off      = {ld_sel[15:3], 3'b000};
  wire        is_null  = (ld_sel[15:3] == 13'd0);
  wire        strict   = (ld_reg == 3'd0) || (ld_reg == 3'd2);
  wire        over     = ({1'b0, off} + 17'd7) > {1'b0, gsize};
  wire        accept   = (st == S_IDLE) && ld_req && (ld_reg < 3'd6);

  wire [31:0] hi_w     = (st == S_WB) ? hi_q : mem_rdata;
  wire        is_code  = hi_w[11];
  wire        type_ok  = (tgt == 3'd0) ? is_code : (!is_code || hi_w[9]);
  wire        gp_hi    = !hi_w[12] || !type_ok;
  wire        np_hi    = !hi_w[15];
  wire [19:0] raw_lim  = {hi_w[19:16], lo_q[15:0]};
  wire [31:0] dec_lim  = hi_w[23] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
  wire [31:0] dec_base = {hi_w[31:24], hi_w[7:0], lo_q[31:16]};
  wire        hi_ok    = (st == S_HI) && mem_ack && !gp_hi && !np_hi;
  wire        commit   = (hi_ok && hi_w[8]) || ((st == S_WB) && mem_ack);

  assign busy      = (st != S_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st == S_WB);
  assign mem_addr  = daddr + ((st == S_LO) ? 32'd0 : 32'd4);
  assign mem_wdata = hi_q | 32'h0000_0100;
  assign cpl       = sel_q[0][1:0];

  wire rd_ok = (rd_idx < 3'd6);
  assign rd_sel    = rd_ok ? sel_q[rd_idx]  : 16'h0;
  assign rd_base   = rd_ok ? base_q[rd_idx] : 32'h0;
  assign rd_limit  = rd_ok ? lim_q[rd_idx]  : 32'h0;
  assign rd_attr   = rd_ok ? attr_q[rd_idx] : 12'h0;
  assign rd_usable = rd_ok && use_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      gbase <= '0; gsize <= '0; daddr <= '0; lo_q <= '0; hi_q <= '0;
      nsel <= '0; tgt <= '0; done <= 1'b0; fault <= 1'b0; fault_code <= '0;
      use_q <= '0;
      for (int k = 0; k < NSEG; k++) begin
        sel_q[k] <= '0; base_q[k] <= '0; lim_q[k] <= '0; attr_q[k] <= '0;
      end
    end else begin
      done <= 1'b0;
      fault <= 1'b0;
      fault_code <= 2'd0;
      if (tbl_wr) begin
        gbase <= tbl_base;
        gsize <= tbl_size;
      end
      case (st)
        S_IDLE: if (accept) begin
          tgt   <= ld_reg;
          nsel  <= ld_sel;
          daddr <= gbase + {16'h0, off};
          if (is_null && strict) begin
            fault <= 1'b1; fault_code <= GP;
          end else if (is_null) begin
            sel_q[ld_reg]  <= ld_sel;
            base_q[ld_reg] <= '0;
            lim_q[ld_reg]  <= '0;
            attr_q[ld_reg] <= '0;
            use_q[ld_reg]  <= 1'b0;
            done <= 1'b1;
          end else if (over) begin
            fault <= 1'b1; fault_code <= GP;
          end else begin
            st <= S_LO;
          end
        end
        S_LO: if (mem_ack) begin
          lo_q <= mem_rdata;
          st   <= S_HI;
        end
        S_HI: if (mem_ack) begin
          hi_q <= mem_rdata;
          if (gp_hi) begin
            fault <= 1'b1; fault_code <= GP; st <= S_IDLE;
          end else if (np_hi) begin
            fault <= 1'b1; fault_code <= NP; st <= S_IDLE;
          end else if (!mem_rdata[8]) begin
            st <= S_WB;
          end
        end
        default: ;
      endcase
      if (commit) begin
        sel_q[tgt]  <= nsel;
        base_q[tgt] <= dec_base;
        lim_q[tgt]  <= dec_lim;
        attr_q[tgt] <= {hi_w[23:20], hi_w[15:9], 1'b1};
        use_q[tgt]  <= 1'b1;
        done <= 1'b1;
        st   <= S_IDLE;
      end
    end
  end

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_null_not_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tgt == 3'd0) |-> use_q[0]);

  assert_wb_sets_accessed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[8]);

  assert_cs_is_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tgt == 3'd0) |-> attr_q[0][3]);

  assert_end_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!busy && !(done && fault)));

  assert_fault_has_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_code == GP || fault_code == NP));

  for (genvar g = 0; g < NSEG; g++) begin : g_hold
    assert_reg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(sel_q[g]) && $stable(base_q[g]) && $stable(use_q[g])));
  end
endmodule

// File: tb/test_seg_load_unit.sv
module test_seg_load_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        tbl_wr = 0, ld_req = 0, mem_ack, mem_req, mem_we;
  logic [31:0] tbl_base = 0, mem_addr, mem_wdata, mem_rdata, rd_base, rd_limit;
  logic [15:0] tbl_size = 0, ld_sel = 0, rd_sel;
  logic [2:0]  ld_reg = 0, rd_idx = 0;
  logic        busy, done, fault, rd_usable;
  logic [1:0]  fault_code, cpl;
  logic [11:0] rd_attr;

  seg_load_unit i_seg_load_unit (.*);

  localparam logic [31:0] DESC [16] = '{
    32'h0, 32'h0,
    32'h1000FFFF, 32'h00CF9A00,
    32'h56780FFF, 32'h12409234,
    32'h0000FFFF, 32'h00401200,
    32'h0000FFFF, 32'h00409900,
    32'h00000000, 32'h00408900,
    32'h00000010, 32'h00C09320,
    32'h00002345, 32'hAB419BCD };

  logic [31:0] mem [64];
  int rd_n, wr_n;
  logic [31:0] rd_a0, rd_a1, wr_a, wr_d;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) mem[k] <= (k >= 16 && k < 32) ? DESC[k-16] : 32'h0;
      mem_ack <= 0; mem_rdata <= 0; rd_n <= 0; wr_n <= 0;
      rd_a0 <= 0; rd_a1 <= 0; wr_a <= 0; wr_d <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[7:2]] <= mem_wdata;
          wr_n <= wr_n + 1; wr_a <= mem_addr; wr_d <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr[7:2]];
          rd_n <= rd_n + 1; rd_a0 <= rd_a1; rd_a1 <= mem_addr;
        end
      end
    end
  end

  // fields: reg, sel, code, base, limit, usable, reads, write, requirement
  localparam logic [92:0] VEC [13] = '{
    {3'd0, 16'h000B, 2'd0, 32'h00001000, 32'hFFFFFFFF, 1'b1, 2'd2, 1'b1, 4'd9},  // R9 R10
    {3'd1, 16'h0010, 2'd0, 32'h12345678, 32'h00000FFF, 1'b1, 2'd2, 1'b1, 4'd7},  // R7
    {3'd2, 16'h0030, 2'd0, 32'h00200000, 32'h00010FFF, 1'b1, 2'd2, 1'b0, 4'd9},  // R9
    {3'd3, 16'h0038, 2'd0, 32'hABCD0000, 32'h00012345, 1'b1, 2'd2, 1'b0, 4'd5},  // R5 boundary, R8
    {3'd4, 16'h0018, 2'd2, 32'h0, 32'h0, 1'b0, 2'd2, 1'b0, 4'd6},                // R6
    {3'd5, 16'h0020, 2'd1, 32'h0, 32'h0, 1'b0, 2'd2, 1'b0, 4'd8},                // R8 exec-only
    {3'd1, 16'h0028, 2'd1, 32'h0, 32'h0, 1'b0, 2'd2, 1'b0, 4'd8},                // R8 system
    {3'd0, 16'h0010, 2'd1, 32'h0, 32'h0, 1'b0, 2'd2, 1'b0, 4'd8},                // R8 data into code
    {3'd4, 16'h0040, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 4'd5},                // R5
    {3'd2, 16'h0000, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 4'd3},                // R3
    {3'd0, 16'h0003, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 4'd3},                // R3
    {3'd5, 16'h0000, 2'd0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 4'd4},                // R4
    {3'd0, 16'h0020, 2'd0, 32'h00000000, 32'h0000FFFF, 1'b1, 2'd2, 1'b0, 4'd10}  // R10
  };

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_sel [6] = '{default: 16'h0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic got, gfault;
  logic [1:0] gcode;
  task automatic do_load(input logic [2:0] r, input logic [15:0] s);
    ld_req = 1; ld_reg = r; ld_sel = s; got = 0; gfault = 0; gcode = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      ld_req = 0;
      if (done || fault) begin got = 1; gfault = fault; gcode = fault_code; end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 fault", fault, 0);
    chk("R1 mem_req", mem_req, 0); chk("R1 cpl", cpl, 0);
    for (int k = 0; k < 6; k++) begin
      rd_idx = k[2:0]; #1;
      chk("R1 sel", rd_sel, 0); chk("R1 usable", rd_usable, 0);
      chk("R1 base", rd_base, 0); chk("R1 limit", rd_limit, 0);
    end
    tbl_wr = 1; tbl_base = 32'h40; tbl_size = 16'h3F;
    @(negedge clk); tbl_wr = 0;

    for (int v = 0; v < 13; v++) begin
      automatic logic [92:0] e = VEC[v];
      automatic logic [2:0]  r = e[92:90];
      automatic logic [15:0] s = e[89:74];
      automatic int rq = e[3:0];
      automatic int r0 = rd_n, w0 = wr_n;
      do_load(r, s);
      chk($sformatf("R%0d row%0d response", rq, v), got, 1);
      chk($sformatf("R%0d row%0d fault", rq, v), gfault, e[73:72] != 0);
      chk($sformatf("R%0d row%0d code", rq, v), gcode, e[73:72]);
      chk($sformatf("R11 row%0d busy after end", v), busy, 0);
      chk($sformatf("R%0d row%0d reads", rq, v), rd_n - r0, e[6:5]);
      chk($sformatf("R7 row%0d writes", v), wr_n - w0, e[4]);
      if (e[6:5] == 2) begin
        chk($sformatf("R2 row%0d addr lo", v), rd_a0, 32'h40 + {16'h0, s[15:3], 3'b0});
        chk($sformatf("R2 row%0d addr hi", v), rd_a1, 32'h44 + {16'h0, s[15:3], 3'b0});
      end
      if (e[4]) begin
        chk($sformatf("R7 row%0d wb addr", v), wr_a, rd_a1);
        chk($sformatf("R7 row%0d wb bit", v), wr_d[8], 1);
      end
      if (e[73:72] == 0) exp_sel[r] = s;
      rd_idx = r; #1;
      chk($sformatf("R6 row%0d selector", v), rd_sel, exp_sel[r]);
      if (e[73:72] == 0) begin
        chk($sformatf("R9 row%0d base", v), rd_base, e[71:40]);
        chk($sformatf("R9 row%0d limit", v), rd_limit, e[39:8]);
        chk($sformatf("R4 row%0d usable", v), rd_usable, e[7]);
      end
      chk($sformatf("R10 row%0d cpl", v), cpl, exp_sel[0][1:0]);
      @(negedge clk);
    end

    // R9 attribute layout on code register (entry 4, accessed already set)
    rd_idx = 0; #1;
    chk("R9 attr", rd_attr, 12'h499);

    // R7 no write-back once accessed is set
    begin
      automatic int w0 = wr_n;
      do_load(3'd1, 16'h0010);
      chk("R7 second load no write", wr_n - w0, 0);
      chk("R7 second load done", gfault, 0);
    end

    // R11 request during busy ignored, done is a single pulse
    ld_req = 1; ld_reg = 3'd4; ld_sel = 16'h0030;
    @(negedge clk);
    chk("R11 busy during load", busy, 1);
    ld_reg = 3'd5; ld_sel = 16'h0010;
    @(negedge clk); ld_req = 0;
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    chk("R11 done seen", done, 1);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
    rd_idx = 5; #1;
    chk("R11 ignored request", rd_sel, exp_sel[5]);
    rd_idx = 4; #1;
    chk("R11 accepted request", rd_sel, 16'h0030);

    // R11 register 7 ignored
    ld_req = 1; ld_reg = 3'd7; ld_sel = 16'h0010;
    @(negedge clk); ld_req = 0;
    chk("R11 bad reg busy", busy, 0);
    chk("R11 bad reg done", done, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule